// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card-side clock from the controller's base clock. The division runs in two cascaded stages. A power-of-two prescaler comes first, selected by a one-hot byte. A linear divisor of 1 to 16 follows it. A double-data-rate flag halves the prescale. The block produces two outputs: a one-cycle tick at the end of every divided period, and a divided clock level whose high phase comes first.

Software programs the two divider fields and the DDR flag while the card clock enable is low. The block copies the settings only while it is stopped, so a divider change can never reshape a period that is in progress. When the enable drops, the current high phase always runs to its end before the output is parked low. A stable flag goes low when a new setting is taken. It goes high once a full period has completed at that setting.

Top module: `sdclk_div`

## Requirements
- R1: The period is N = P × (D + 1) base-clock cycles, where D is `div_sel` (0..15) and P is the prescale. While running, `card_tick` is high for exactly one cycle at the last cycle of each period.
- R2: In SDR mode (`ddr_mode` = 0), a `presc_sel` of 0x00 gives P = 1, and a single set bit k gives P = 2^(k+1). So 0x01 gives 2 and 0x80 gives 256.
- R3: In DDR mode (`ddr_mode` = 1), a single set bit k gives P = 2^k, and 0x00 still gives P = 1.
- R4: When several bits of `presc_sel` are set, only the highest set bit decides P.
- R5: Within each period, `card_clk` is high for the first ceil(N/2) cycles and low for the rest. With N = 1 it stays high while running.
- R6: In the cycle after `card_clk_en` is first sampled high while stopped, the period begins: `card_clk` is high, and the first tick comes N−1 cycles later.
- R7: When `card_clk_en` is low, the divider keeps counting until the current high phase has ended and then stops. While stopped, `card_clk` and `card_tick` stay low. A high phase is never shortened.
- R8: The block takes `presc_sel`, `div_sel` and `ddr_mode` only while it is stopped. Changes to them while it is running have no effect on the outputs.
- R9: `clk_stable` is low after reset. It falls in the cycle after a different setting is taken while stopped. It rises in the cycle after the first period end at the current setting, and otherwise keeps its value.
- R10: During and right after reset, `card_tick`, `card_clk` and `clk_stable` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | 8 | One-hot prescale select (control register bits 15:8) |
| div_sel | input | 4 | Divisor minus one (control register bits 7:4) |
| ddr_mode | input | 1 | Halves the prescale when set |
| card_clk_en | input | 1 | Card clock enable |
| card_tick | output | 1 | One-cycle pulse at each period end |
| card_clk | output | 1 | Divided clock level, high phase first |
| clk_stable | output | 1 | Current setting has completed a full period |

## Verification
A stop request can land in the cycle that ends a period. That same edge must then both raise `clk_stable` and park the divider. This is provoked by random runs that drop the enable at random positions, including the last cycle of a period, and by directed disables at every position of an 8-cycle period. A second collision is a setting change that arrives together with the enable rising. The new setting must govern the very first period, and the stable flag must fall on that same edge. A cycle-level bench model judges both collisions from the requirements.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_RUN  = 1'b1
    } ck_mode_e;

endpackage

// File: rtl/sdclk_cfg_hold.sv
module sdclk_cfg_hold #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [PRE_W-1:0] pre_in,
    input  logic [DIV_W-1:0] div_in,
    input  logic             ddr_in,
    output logic [PRE_W-1:0] pre_nx,
    output logic [DIV_W-1:0] div_nx,
    output logic             ddr_nx,
    output logic             cfg_changed
);

    typedef struct packed {
        logic             ddr;
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t hold_d, hold_q;
    cfg_t cur;

    always_comb begin
        cur.ddr = ddr_in;
        cur.pre = pre_in;
        cur.div = div_in;
        // settings pass through only while the divider is stopped
        hold_d      = running ? hold_q : cur;
        cfg_changed = (hold_d != hold_q);
        pre_nx      = hold_d.pre;
        div_nx      = hold_d.div;
        ddr_nx      = hold_d.ddr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(running) |-> $stable(hold_q));

endmodule

// File: rtl/sdclk_cfg_decode.sv
module sdclk_cfg_decode #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4,
    parameter int NW    = PRE_W + DIV_W + 1
) (
    input  logic [PRE_W-1:0] pre_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             ddr,
    output logic [NW-1:0]    period_m1,
    output logic [NW-1:0]    high_len
);

    localparam int SW = $clog2(PRE_W + 2);

    logic [PRE_W-1:0] msb_hit;
    logic [SW-1:0]    shift;
    logic [NW-1:0]    base;
    logic [NW-1:0]    period;

    // one flag per bit: set only for the highest set bit
    for (genvar i = 0; i < PRE_W; i++) begin : g_msb
        if (i == PRE_W - 1) begin : g_top
            assign msb_hit[i] = pre_sel[i];
        end else begin : g_low
            assign msb_hit[i] = pre_sel[i] & ~(|pre_sel[PRE_W-1:i+1]);
        end
    end

    always_comb begin
        shift = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (msb_hit[i]) begin
                shift = ddr ? SW'(i) : SW'(i + 1);
            end
        end
        base      = {{(NW-DIV_W){1'b0}}, div_sel} + NW'(1);
        period    = base << shift;
        period_m1 = period - NW'(1);
        high_len  = (period + NW'(1)) >> 1;
    end

endmodule

// File: rtl/sdclk_gate_ctr.sv
module sdclk_gate_ctr
    import sdclk_pkg::*;
#(
    parameter int NW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NW-1:0] period_m1,
    input  logic [NW-1:0] high_len,
    output logic          running,
    output logic          at_end,
    output logic          tick,
    output logic          card_clk
);

    typedef struct packed {
        ck_mode_e      mode;
        logic [NW-1:0] cnt;
        logic          tick;
        logic          clk_o;
    } ctr_t;

    ctr_t st_d, st_q;
    logic last;
    logic high_done;

    always_comb begin
        st_d      = st_q;
        last      = (st_q.cnt == period_m1);
        high_done = (({1'b0, st_q.cnt} + (NW+1)'(1)) >= {1'b0, high_len});
        unique case (st_q.mode)
            MODE_IDLE: begin
                if (en) begin
                    st_d.mode = MODE_RUN;
                    st_d.cnt  = '0;
                end
            end
            MODE_RUN: begin
                if (!en && high_done) begin
                    st_d.mode = MODE_IDLE;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = last ? '0 : st_q.cnt + NW'(1);
                end
            end
            default: st_d.mode = MODE_IDLE;
        endcase
        st_d.clk_o = (st_d.mode == MODE_RUN) && (st_d.cnt < high_len);
        st_d.tick  = (st_d.mode == MODE_RUN) && (st_d.cnt == period_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_IDLE, cnt: '0, tick: 1'b0, clk_o: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign running  = (st_q.mode == MODE_RUN);
    assign at_end   = running && last;
    assign tick     = st_q.tick;
    assign card_clk = st_q.clk_o;

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (st_q.cnt <= period_m1));

    assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tick && period_m1 != '0) |=> !st_q.tick);

    assert_tick_in_low_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tick && period_m1 != '0) |-> !st_q.clk_o);

    assert_high_not_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.clk_o) |-> (($past(st_q.cnt) + NW'(1)) == $past(high_len)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !$past(running)) |-> (!st_q.clk_o && !st_q.tick));

endmodule

// File: rtl/sdclk_stable_mon.sv
module sdclk_stable_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_changed,
    input  logic at_end,
    output logic stable
);

    logic stable_d, stable_q;

    always_comb begin
        stable_d = stable_q;
        if (cfg_changed) begin
            stable_d = 1'b0;
        end else if (at_end) begin
            stable_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
        end else begin
            stable_q <= stable_d;
        end
    end

    assign stable = stable_q;

    assert_stable_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable_q) |-> $past(at_end));

    assert_stable_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_changed |=> !stable_q);

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] presc_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             ddr_mode,
    input  logic             card_clk_en,
    output logic             card_tick,
    output logic             card_clk,
    output logic             clk_stable
);

    localparam int NW = PRE_W + DIV_W + 1;

    logic             running;
    logic             at_end;
    logic             cfg_changed;
    logic [PRE_W-1:0] pre_nx;
    logic [DIV_W-1:0] div_nx;
    logic             ddr_nx;
    logic [NW-1:0]    period_m1;
    logic [NW-1:0]    high_len;

    sdclk_cfg_hold #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .running     (running),
        .pre_in      (presc_sel),
        .div_in      (div_sel),
        .ddr_in      (ddr_mode),
        .pre_nx      (pre_nx),
        .div_nx      (div_nx),
        .ddr_nx      (ddr_nx),
        .cfg_changed (cfg_changed)
    );

    sdclk_cfg_decode #(.PRE_W(PRE_W), .DIV_W(DIV_W), .NW(NW)) u_dec (
        .pre_sel   (pre_nx),
        .div_sel   (div_nx),
        .ddr       (ddr_nx),
        .period_m1 (period_m1),
        .high_len  (high_len)
    );

    sdclk_gate_ctr #(.NW(NW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (card_clk_en),
        .period_m1 (period_m1),
        .high_len  (high_len),
        .running   (running),
        .at_end    (at_end),
        .tick      (card_tick),
        .card_clk  (card_clk)
    );

    sdclk_stable_mon u_stab (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_changed (cfg_changed),
        .at_end      (at_end),
        .stable      (clk_stable)
    );

    assert_period_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (high_len != '0) && ({1'b0, high_len} <= ({1'b0, period_m1} + (NW+1)'(1))));

endmodule

// File: tb/sdclk_div_tb.sv
module sdclk_div_tb_top;

    logic       clk;
    logic       rst_n;
    logic [7:0] presc_sel;
    logic [3:0] div_sel;
    logic       ddr_mode;
    logic       card_clk_en;
    logic       card_tick;
    logic       card_clk;
    logic       clk_stable;

    int n_chk;
    int n_bad;
    bit done;

    // reference state
    bit         m_run;
    int         m_pos;
    bit         m_st;
    logic [7:0] m_pre;
    logic [3:0] m_div;
    logic       m_ddr;

    sdclk_div dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .presc_sel   (presc_sel),
        .div_sel     (div_sel),
        .ddr_mode    (ddr_mode),
        .card_clk_en (card_clk_en),
        .card_tick   (card_tick),
        .card_clk    (card_clk),
        .clk_stable  (clk_stable)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic int pre_of(logic [7:0] f, logic d);
        int k = -1;
        for (int i = 0; i < 8; i++) if (f[i]) k = i;
        if (k < 0) return 1;
        return d ? (1 << k) : (1 << (k + 1));
    endfunction

    function automatic int per_of(logic [7:0] f, logic [3:0] dv, logic d);
        return pre_of(f, d) * (int'(dv) + 1);
    endfunction

    task automatic check(input string tag, input string name, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got=%0b exp=%0b t=%0t", tag, name, got, exp, $time);
        end
    endtask

    // one base-clock cycle: update the model from driven inputs, then compare
    task automatic step(input string tag);
        int n_now;
        int h_now;
        bit chg;
        if (!m_run) begin
            chg = (presc_sel != m_pre) || (div_sel != m_div) || (ddr_mode != m_ddr);
            m_pre = presc_sel;
            m_div = div_sel;
            m_ddr = ddr_mode;
            if (chg) m_st = 1'b0;
            if (card_clk_en) begin
                m_run = 1'b1;
                m_pos = 0;
            end
        end else begin
            n_now = per_of(m_pre, m_div, m_ddr);
            h_now = (n_now + 1) / 2;
            if (m_pos == n_now - 1) m_st = 1'b1;
            if (!card_clk_en && (m_pos + 1 >= h_now)) begin
                m_run = 1'b0;
                m_pos = 0;
            end else begin
                m_pos = (m_pos == n_now - 1) ? 0 : m_pos + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        n_now = per_of(m_pre, m_div, m_ddr);
        h_now = (n_now + 1) / 2;
        check(tag, "card_tick", card_tick, m_run && (m_pos == n_now - 1));
        check(tag, "card_clk", card_clk, m_run && (m_pos < h_now));
        check(tag, "clk_stable", clk_stable, m_st);
    endtask

    task automatic set_cfg(input logic [7:0] p, input logic [3:0] dv, input logic d);
        presc_sel = p;
        div_sel   = dv;
        ddr_mode  = d;
    endtask

    task automatic stop_all(input string tag);
        card_clk_en = 1'b0;
        while (m_run) step(tag);
        step(tag);
    endtask

    task automatic run_for(input string tag, input int cycles);
        card_clk_en = 1'b1;
        for (int i = 0; i < cycles; i++) step(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int n;
        logic [7:0] p;
        seed = 32'h5D1C_0A7B;
        void'($urandom(seed));
        n_chk = 0;
        n_bad = 0;
        m_run = 0; m_pos = 0; m_st = 0;
        m_pre = '0; m_div = '0; m_ddr = 1'b0;
        rst_n = 1'b0;
        card_clk_en = 1'b0;
        set_cfg(8'h00, 4'h0, 1'b0);
        repeat (3) @(negedge clk);
        // R10: outputs low while in reset
        check("R10", "card_tick", card_tick, 1'b0);
        check("R10", "card_clk", card_clk, 1'b0);
        check("R10", "clk_stable", clk_stable, 1'b0);
        rst_n = 1'b1;
        step("R10");
        step("R10");

        // R6: start of the first period, N = 6
        set_cfg(8'h01, 4'h2, 1'b0);
        step("R9");
        run_for("R6", 14);
        stop_all("R7");

        // R2: largest SDR setting, N = 4096
        set_cfg(8'h80, 4'hF, 1'b0);
        step("R2");
        run_for("R2", 4100);
        stop_all("R2");

        // R3: DDR with empty and lowest prescale give P = 1
        set_cfg(8'h00, 4'h0, 1'b1);
        step("R3");
        run_for("R3", 5);
        stop_all("R3");
        set_cfg(8'h01, 4'h2, 1'b1);
        step("R3");
        run_for("R3", 10);
        stop_all("R3");
        set_cfg(8'h10, 4'h0, 1'b1);
        step("R3");
        run_for("R3", 40);
        stop_all("R3");

        // R4: several bits set, highest one wins
        set_cfg(8'h0B, 4'h1, 1'b0);
        step("R4");
        run_for("R4", 40);
        stop_all("R4");

        // R7: drop enable at every position of an 8-cycle period
        for (int k = 1; k <= 9; k++) begin
            set_cfg(8'h02, 4'h1, 1'b0);
            step("R7");
            run_for("R7", k);
            stop_all("R7");
            step("R7");
        end

        // R8: setting changes during a run are ignored
        set_cfg(8'h04, 4'h0, 1'b0);
        step("R8");
        run_for("R8", 5);
        set_cfg(8'h01, 4'h3, 1'b1);
        run_for("R8", 30);
        set_cfg(8'h04, 4'h0, 1'b0);
        stop_all("R8");
        // R9: same setting again keeps the flag high
        step("R9");
        run_for("R9", 3);
        stop_all("R9");

        // random mix
        for (int it = 0; it < 60; it++) begin
            case ($urandom % 8)
                0: p = 8'h00;
                1: p = 8'($urandom % 64);
                default: p = 8'(1 << ($urandom % 5));
            endcase
            set_cfg(p, 4'($urandom % 16), 1'($urandom % 2));
            step("R9");
            step("R9");
            n = per_of(presc_sel, div_sel, ddr_mode);
            card_clk_en = 1'b1;
            for (int c = 0; c < int'($urandom % (2 * n + 8)) + 1; c++) begin
                if (($urandom % 8) == 0)
                    set_cfg(8'($urandom), 4'($urandom), 1'($urandom % 2));
                step("R1 R5 R8 R9");
            end
            stop_all("R7 R9");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule